// File: doc/BRIEF.md
# Dual-Lane Bidirectional Registered Transceiver

This block sits between two shared buses, called A and B, and stores data in each direction. It has byte lanes, two by default. Each lane holds two independent storage registers. The forward register takes its data from the A side and presents it on the B side. The return register takes its data from the B side and presents it on the A side.

Each register has three controls of its own: a capture clock, an active-low capture enable and an active-low output enable. The output enable acts only on the tri-state driver, so a register can take new data while its port is released. Either port can be left at high impedance for other bus agents to use.

The lanes share no logic. To use the block as one wide transceiver, connect the matching control bits of all lanes together. The block has no reset: a register holds an unknown value until its first enabled capture.

Top module: `dual_lane_reg_xcvr`

## Requirements
- R1: The controls of one lane never change the registers or the port pins of any other lane.
- R2: The forward register of a lane loads that lane's A byte on a rising edge of `fwd_clk` while `fwd_cap_n` is 0.
- R3: A register keeps its contents when its capture enable is 1 at a rising clock edge. It also keeps them when the data input changes with no clock edge, whatever the enable level.
- R4: When `fwd_drv_n` is 0, the lane's B byte carries the forward register. When it is 1, the block releases the B byte to high impedance, so a value driven from outside reads back unchanged.
- R5: The output enable has no effect on capture. A register loaded while its driver is off shows the new value once the driver is turned on.
- R6: The return register loads the lane's B byte on a rising edge of `ret_clk` while `ret_cap_n` is 0. It drives the A byte when `ret_drv_n` is 0 and releases the A byte when `ret_drv_n` is 1.
- R7: The two registers of a lane store their data independently. With both output enables at 0, the A byte shows the return register and the B byte shows the forward register at the same time.
- R8: Lane k occupies bits [8k+7:8k] of both buses. With the same control values applied to all lanes, the block acts as one 16-bit registered transceiver.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fwd_clk | input | LANES | Per-lane capture clock for the A-to-B register |
| fwd_cap_n | input | LANES | Per-lane active-low capture enable, A-to-B |
| fwd_drv_n | input | LANES | Per-lane active-low B-side output enable |
| ret_clk | input | LANES | Per-lane capture clock for the B-to-A register |
| ret_cap_n | input | LANES | Per-lane active-low capture enable, B-to-A |
| ret_drv_n | input | LANES | Per-lane active-low A-side output enable |
| a_io | inout | LANES*LANE_W | A-side bus: A-to-B data in, B-to-A tri-state data out |
| b_io | inout | LANES*LANE_W | B-side bus: B-to-A data in, A-to-B tri-state data out |

## Verification
The assertions check, on every capture clock edge, three things. An enabled edge loads the register from its port, including while the driver is off. A disabled edge leaves the register unchanged. The return path mirrors the forward path at lane level. The bench scenarios cover what no clock edge can show. These are high impedance at the pins, read as an external value passing through. They also cover holding through data changes with no edge, two drivers running at once on one lane, isolation between lanes, and the lanes acting together as one wide word.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
   typedef enum logic {DIR_FWD = 1'b0, DIR_RET = 1'b1} xcvr_dir_e;
   localparam int unsigned XCVR_LANE_W_DEF = 8;
   localparam int unsigned XCVR_LANES_DEF  = 2;
endpackage

// File: rtl/xcvr_dir_reg.sv
module xcvr_dir_reg
   import xcvr_pkg::*;
#(
   parameter int unsigned W   = XCVR_LANE_W_DEF,
   parameter xcvr_dir_e   DIR = DIR_FWD
) (
   input  logic         clk_i,
   input  logic         cap_n_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   // No reset on purpose: contents are undefined until the first enabled edge.
   always_ff @(posedge clk_i) begin
      if (!cap_n_i) q_o <= d_i;
   end

   AST_CAPTURE: assert property (@(posedge clk_i) (!cap_n_i && !$isunknown(d_i)) |=> (q_o == $past(d_i))) else $error("capture lost (%s)", DIR.name()); // R2
   AST_HOLD: assert property (@(posedge clk_i) (cap_n_i && !$isunknown(q_o)) |=> $stable(q_o)) else $error("hold broken (%s)", DIR.name()); // R3
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
   import xcvr_pkg::*;
#(
   parameter int unsigned W = XCVR_LANE_W_DEF
) (
   input  logic         fwd_clk,
   input  logic         fwd_cap_n,
   input  logic         fwd_drv_n,
   input  logic         ret_clk,
   input  logic         ret_cap_n,
   input  logic         ret_drv_n,
   inout  wire  [W-1:0] a_io,
   inout  wire  [W-1:0] b_io
);
   logic [W-1:0] fwd_q;
   logic [W-1:0] ret_q;

   xcvr_dir_reg #(.W(W), .DIR(DIR_FWD)) u_fwd (
      .clk_i  (fwd_clk),
      .cap_n_i(fwd_cap_n),
      .d_i    (a_io),
      .q_o    (fwd_q)
   );

   xcvr_dir_reg #(.W(W), .DIR(DIR_RET)) u_ret (
      .clk_i  (ret_clk),
      .cap_n_i(ret_cap_n),
      .d_i    (b_io),
      .q_o    (ret_q)
   );

   // Output enables gate only the pin drivers, never the registers.
   assign b_io = fwd_drv_n ? {W{1'bz}} : fwd_q;
   assign a_io = ret_drv_n ? {W{1'bz}} : ret_q;

   AST_OE_DECOUPLE: assert property (@(posedge fwd_clk) (!fwd_cap_n && fwd_drv_n && !$isunknown(a_io)) |=> (fwd_q == $past(a_io))) else $error("capture blocked by output enable"); // R5
   AST_MIRROR: assert property (@(posedge ret_clk) (!ret_cap_n && !$isunknown(b_io)) |=> (ret_q == $past(b_io))) else $error("return path capture lost"); // R6
endmodule

// File: rtl/dual_lane_reg_xcvr.sv
module dual_lane_reg_xcvr
   import xcvr_pkg::*;
#(
   parameter int unsigned LANES  = XCVR_LANES_DEF,
   parameter int unsigned LANE_W = XCVR_LANE_W_DEF
) (
   input  logic [LANES-1:0]        fwd_clk,
   input  logic [LANES-1:0]        fwd_cap_n,
   input  logic [LANES-1:0]        fwd_drv_n,
   input  logic [LANES-1:0]        ret_clk,
   input  logic [LANES-1:0]        ret_cap_n,
   input  logic [LANES-1:0]        ret_drv_n,
   inout  wire  [LANES*LANE_W-1:0] a_io,
   inout  wire  [LANES*LANE_W-1:0] b_io
);
   localparam int unsigned BUS_W = LANES * LANE_W;

   if (LANES < 1) begin : g_bad_lanes
      $error("LANES must be at least 1");
   end
   if (LANE_W < 1) begin : g_bad_width
      $error("LANE_W must be at least 1");
   end
   if (BUS_W > 4096) begin : g_bad_bus
      $error("bus wider than supported");
   end

   // Lane k owns bits [k*LANE_W +: LANE_W]; lanes share nothing.
   for (genvar k = 0; k < LANES; k++) begin : g_lane
      xcvr_lane #(.W(LANE_W)) u_lane (
         .fwd_clk  (fwd_clk[k]),
         .fwd_cap_n(fwd_cap_n[k]),
         .fwd_drv_n(fwd_drv_n[k]),
         .ret_clk  (ret_clk[k]),
         .ret_cap_n(ret_cap_n[k]),
         .ret_drv_n(ret_drv_n[k]),
         .a_io     (a_io[k*LANE_W +: LANE_W]),
         .b_io     (b_io[k*LANE_W +: LANE_W])
      );
   end
endmodule

// File: tb/tb_dual_lane_reg_xcvr.sv
module tb_dual_lane_reg_xcvr;
   localparam int LANES = 2;
   localparam int W = 8;
   localparam int BW = LANES * W;

   typedef struct {
      int         port;   // 0 = A side, 1 = B side
      int         lane;
      logic [7:0] val;
      string      tag;
   } exp_t;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic [LANES-1:0] fwd_clk = '0, fwd_cap_n = '1, fwd_drv_n = '1;
   logic [LANES-1:0] ret_clk = '0, ret_cap_n = '1, ret_drv_n = '1;
   logic [BW-1:0] a_val = '0, a_en = '0, b_val = '0, b_en = '0;
   wire  [BW-1:0] a_io, b_io;

   for (genvar i = 0; i < BW; i++) begin : g_pad
      assign a_io[i] = a_en[i] ? a_val[i] : 1'bz;
      assign b_io[i] = b_en[i] ? b_val[i] : 1'bz;
   end

   dual_lane_reg_xcvr #(.LANES(LANES), .LANE_W(W)) dut (
      .fwd_clk(fwd_clk), .fwd_cap_n(fwd_cap_n), .fwd_drv_n(fwd_drv_n),
      .ret_clk(ret_clk), .ret_cap_n(ret_cap_n), .ret_drv_n(ret_drv_n),
      .a_io(a_io), .b_io(b_io)
   );

   exp_t sb[$];
   int checks = 0;
   int errors = 0;
   int cyc = 0;

   // Monitor: pops expectations and compares against the pins at the falling edge.
   always @(negedge clk) begin
      while (sb.size() > 0) begin
         exp_t it;
         logic [7:0] obs;
         it = sb.pop_front();
         obs = it.port ? b_io[it.lane*W +: W] : a_io[it.lane*W +: W];
         checks++;
         if (obs !== it.val) begin
            errors++;
            $display("FAIL %s lane%0d port%s: got %h expected %h",
                     it.tag, it.lane, it.port ? "B" : "A", obs, it.val);
         end
      end
   end

   task automatic drive(int port, int lane, logic [7:0] v);
      if (port == 0) begin a_val[lane*W +: W] = v; a_en[lane*W +: W] = '1; end
      else           begin b_val[lane*W +: W] = v; b_en[lane*W +: W] = '1; end
   endtask

   task automatic release_pin(int port, int lane);
      if (port == 0) a_en[lane*W +: W] = '0;
      else           b_en[lane*W +: W] = '0;
   endtask

   // dir 0 = forward (A into register), dir 1 = return (B into register)
   task automatic cap(int dir, int lane, logic [7:0] v, bit en);
      @(posedge clk);
      #1;
      if (dir == 0) ret_drv_n[lane] = 1'b1; else fwd_drv_n[lane] = 1'b1;
      drive(dir, lane, v);
      if (dir == 0) fwd_cap_n[lane] = !en; else ret_cap_n[lane] = !en;
      #2;
      if (dir == 0) fwd_clk[lane] = 1'b1; else ret_clk[lane] = 1'b1;
      #2;
      if (dir == 0) fwd_clk[lane] = 1'b0; else ret_clk[lane] = 1'b0;
      #1;
      if (dir == 0) fwd_cap_n[lane] = 1'b1; else ret_cap_n[lane] = 1'b1;
      release_pin(dir, lane);
   endtask

   // Enable (en=1) reads the register; disable (en=0) drives v from outside and expects it back.
   task automatic look(int dir, int lane, bit en, logic [7:0] v, string tag);
      exp_t it;
      @(posedge clk);
      #1;
      if (dir == 0) fwd_drv_n[lane] = !en; else ret_drv_n[lane] = !en;
      #1;
      if (!en) drive(1 - dir, lane, v);
      #6;
      it.port = (dir == 0) ? 1 : 0;
      it.lane = lane;
      it.val  = v;
      it.tag  = tag;
      sb.push_back(it);
      @(negedge clk);
      #1;
      if (!en) release_pin(1 - dir, lane);
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   initial begin
      repeat (2) @(posedge clk);
      // Idle state: every port released (R4, R6)
      look(0, 0, 0, 8'hC3, "R4 idle B released");
      look(0, 1, 0, 8'h3C, "R4 idle B released");
      look(1, 0, 0, 8'h81, "R6 idle A released");
      look(1, 1, 0, 8'h18, "R6 idle A released");

      // Forward capture on both lanes
      cap(0, 0, 8'hA5, 1);
      look(0, 0, 1, 8'hA5, "R2 capture lane0");
      cap(0, 1, 8'h3C, 1);
      look(0, 1, 1, 8'h3C, "R2 capture lane1");
      look(0, 0, 1, 8'hA5, "R1 lane0 untouched by lane1");

      // Hold with enable high
      cap(0, 0, 8'hFF, 0);
      look(0, 0, 1, 8'hA5, "R3 hold enable high");

      // Hold with enable low but no edge
      @(posedge clk); #1; drive(0, 0, 8'h11); fwd_cap_n[0] = 1'b0;
      look(0, 0, 1, 8'hA5, "R3 hold no edge");
      @(posedge clk); #1; fwd_cap_n[0] = 1'b1; release_pin(0, 0);

      // Disable, then capture while disabled
      look(0, 0, 0, 8'h0F, "R4 B released when disabled");
      cap(0, 0, 8'h5A, 1);
      look(0, 0, 1, 8'h5A, "R5 capture while driver off");

      // Return path on both lanes
      cap(1, 0, 8'hC3, 1);
      look(1, 0, 1, 8'hC3, "R6 return capture lane0");
      cap(1, 1, 8'h96, 1);
      look(1, 1, 1, 8'h96, "R6 return capture lane1");
      cap(1, 0, 8'h00, 0);
      look(1, 0, 1, 8'hC3, "R3 return hold");
      look(1, 0, 0, 8'hE7, "R6 A released");

      // Both drivers active on lane 1
      look(0, 1, 1, 8'h3C, "R7 forward kept after return capture");
      look(1, 1, 1, 8'h96, "R7 return with forward driving");
      look(0, 1, 1, 8'h3C, "R7 forward with return driving");
      look(1, 1, 0, 8'h24, "R6 release lane1 A");

      // Lane 1 activity leaves lane 0 alone
      cap(0, 1, 8'h77, 1);
      look(0, 1, 1, 8'h77, "R1 lane1 new value");
      look(0, 0, 1, 8'h5A, "R1 lane0 unaffected");
      cap(1, 1, 8'h42, 1);
      look(1, 0, 1, 8'hC3, "R1 lane0 return unaffected");

      // Controls tied together: one 16-bit word
      @(posedge clk); #1;
      ret_drv_n = '1; fwd_drv_n = '1;
      a_val = 16'h1234; a_en = '1; fwd_cap_n = '0;
      #2 fwd_clk = '1;
      #2 fwd_clk = '0;
      #1 fwd_cap_n = '1; a_en = '0;
      look(0, 0, 1, 8'h34, "R8 wide low byte");
      look(0, 1, 1, 8'h12, "R8 wide high byte");

      @(negedge clk); #2;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule